// File: doc/BRIEF.md
# H-Bridge Recirculation Gate Sequencer

This block drives the four power switches of one H-bridge: a high-side (source) and a low-side (sink) switch on leg A and on leg B. From the bridge's per-cycle state, it builds the target gate pattern. That state is the current direction, whether the bridge is in its drive period or its decay period, the decay flavour (fast or slow), and whether the bridge is allowed to run at all. During the decay period it applies one of four synchronous-rectification policies. Two of these policies shut rectification off early. One does so when the load current reaches zero. The other does so when a reversed current reaches the limit.

Every switch output is registered and appears one clock after the inputs that cause it. A per-leg dead-time stage removes a switch at once when the pattern no longer asks for it. It holds back any switch whose partner on the same leg was on until that partner has been off for a fixed number of clocks. A pattern change that swaps a leg's switches therefore shows a gap on that leg.

The block runs on a timing clock (750 ns dead time at 4 MHz with the default count). It sits between the PWM timer, which says drive or decay, and the gate drivers.

Top module: `hbr_gate_seq`

## Requirements
- R1: While reset is high and on the first sample after it, all four switch outputs are low.
- R2: In the drive period (drive_on=1) with the bridge active, phase=1 turns on src_a and snk_b, and phase=0 turns on src_b and snk_a. The outputs appear one clock after the inputs, subject to R11.
- R3: If bridge_en=0, idle=1 or fault=1, all four outputs are low from the next clock.
- R4: In fast decay (drive_on=0, decay_fast=1) under policy 00 or 10, with rectification not shut off, the opposite diagonal is turned on. Phase=1 gives src_b and snk_a; phase=0 gives src_a and snk_b.
- R5: In slow decay (decay_fast=0) under policy 00 or 10, with rectification not shut off, both sink switches are on and both sources are off.
- R6: Under policy 01 (rectification disabled), no switch is on during the decay period.
- R7: Under policy 00 (active), zero_cur=1 in the decay period turns all switches off from the next clock. They stay off for the rest of that decay period even after zero_cur falls, until drive_on=1 or the bridge goes inactive. Under this policy, rev_limit has no effect.
- R8: Under policy 10 (passive), rev_limit=1 in the decay period shuts rectification off in the same latched way as R7. Under this policy, zero_cur has no effect.
- R9: Under policy 11 (low side only), both sources stay off in the decay period. Slow decay turns on both sinks. Fast decay turns on only the sink of the opposite diagonal: snk_a for phase=1 and snk_b for phase=0. Under this policy, zero_cur and rev_limit have no effect.
- R10: The source and sink of the same leg are never on together.
- R11: A switch that the pattern no longer wants turns off at the next clock. A switch turns on only once its leg partner has been off for DEAD clocks (default 3); after reset no wait is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_en | input | 1 | Bridge allowed to conduct (current setting non-zero) |
| idle | input | 1 | Low-power idle state, forces all switches off |
| fault | input | 1 | Protection fault, forces all switches off |
| phase | input | 1 | Current direction: 1 drives A high and B low |
| drive_on | input | 1 | 1 in the drive period, 0 in the decay (off) period |
| decay_fast | input | 1 | Decay flavour: 1 fast, 0 slow |
| rect_policy | input | 2 | Rectification policy: 00 active, 01 disabled, 10 passive, 11 low side only |
| zero_cur | input | 1 | Load current has reached zero |
| rev_limit | input | 1 | Reversed load current has reached the limit |
| src_a | output | 1 | Leg A high-side enable |
| snk_a | output | 1 | Leg A low-side enable |
| src_b | output | 1 | Leg B high-side enable |
| snk_b | output | 1 | Leg B low-side enable |

## Verification
The main function is tried with input segments held for one to eight clocks. Short segments exercise the cases where a phase or decay change is still waiting out its dead time, and long ones show the settled pattern of each policy. The zero-current and reverse-limit detects toggle every clock inside a decay segment. This separates a latched shut-off from one that merely follows the detect, and it shows which detect each policy listens to. A directed phase reversal checks the exact three-clock gap on both legs. Rare idle, fault and disable pulses are mixed into the random stream to check the forced-off path from every state.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int LEGS = 2;

    typedef enum logic [1:0] {
        POL_ACTIVE  = 2'b00,
        POL_NONE    = 2'b01,
        POL_PASSIVE = 2'b10,
        POL_LOWSIDE = 2'b11
    } rect_pol_e;

    typedef struct packed {
        logic src_a;
        logic snk_a;
        logic src_b;
        logic snk_b;
    } gate_set_t;

    // Target switch pattern before dead-time shaping
    function automatic gate_set_t decode_gates(
        input logic      active,
        input logic      drive_on,
        input logic      phase,
        input logic      fast,
        input rect_pol_e pol,
        input logic      killed
    );
        gate_set_t g;
        g = '0;
        if (active) begin
            if (drive_on) begin
                if (phase) begin
                    g.src_a = 1'b1;
                    g.snk_b = 1'b1;
                end else begin
                    g.src_b = 1'b1;
                    g.snk_a = 1'b1;
                end
            end else begin
                case (pol)
                    POL_NONE: g = '0;
                    POL_LOWSIDE: begin
                        if (fast) begin
                            g.snk_a = phase;
                            g.snk_b = !phase;
                        end else begin
                            g.snk_a = 1'b1;
                            g.snk_b = 1'b1;
                        end
                    end
                    default: begin
                        if (!killed) begin
                            if (fast) begin
                                g.src_a = !phase;
                                g.snk_b = !phase;
                                g.src_b = phase;
                                g.snk_a = phase;
                            end else begin
                                g.snk_a = 1'b1;
                                g.snk_b = 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/hbr_rect_guard.sv
module hbr_rect_guard
    import hbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      drive_on,
    input  rect_pol_e pol,
    input  logic      zero_cur,
    input  logic      rev_limit,
    output logic      killed
);
    logic kill_q;
    logic hit;

    always_comb begin
        hit = ((pol == POL_ACTIVE)  && zero_cur) ||
              ((pol == POL_PASSIVE) && rev_limit);
    end

    // Shut-off holds for the rest of the decay period
    always_ff @(posedge clk) begin
        if (rst) begin
            kill_q <= 1'b0;
        end else if (active && !drive_on) begin
            kill_q <= kill_q | hit;
        end else begin
            kill_q <= 1'b0;
        end
    end

    assign killed = kill_q | hit;

endmodule

// File: rtl/hbr_pattern.sv
module hbr_pattern
    import hbr_pkg::*;
(
    input  logic            bridge_en,
    input  logic            idle,
    input  logic            fault,
    input  logic            phase,
    input  logic            drive_on,
    input  logic            decay_fast,
    input  rect_pol_e       pol,
    input  logic            killed,
    output logic            active,
    output logic [LEGS-1:0] want_hi,
    output logic [LEGS-1:0] want_lo
);
    gate_set_t tgt;

    always_comb begin
        active     = bridge_en && !idle && !fault;
        tgt        = decode_gates(active, drive_on, phase, decay_fast, pol, killed);
        want_hi[0] = tgt.src_a;
        want_lo[0] = tgt.snk_a;
        want_hi[1] = tgt.src_b;
        want_lo[1] = tgt.snk_b;
    end

endmodule

// File: rtl/hbr_leg.sv
module hbr_leg #(
    parameter int DEAD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic want_hi,
    input  logic want_lo,
    output logic hi,
    output logic lo
);
    localparam int CW   = (DEAD > 2) ? $clog2(DEAD) : 1;
    localparam logic [CW-1:0] CMAX = CW'(DEAD - 1);

    logic          hi_q, lo_q;
    logic [CW-1:0] hi_off_cnt, lo_off_cnt;
    logic          hi_ok, lo_ok;

    always_comb begin
        hi_ok = !lo_q && (lo_off_cnt == CMAX);
        lo_ok = !hi_q && (hi_off_cnt == CMAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= 1'b0;
            lo_q       <= 1'b0;
            hi_off_cnt <= CMAX;
            lo_off_cnt <= CMAX;
        end else begin
            hi_q <= want_hi && !want_lo && (hi_q || hi_ok);
            lo_q <= want_lo && !want_hi && (lo_q || lo_ok);
            if (hi_q)                  hi_off_cnt <= '0;
            else if (hi_off_cnt != CMAX) hi_off_cnt <= hi_off_cnt + 1'b1;
            if (lo_q)                  lo_off_cnt <= '0;
            else if (lo_off_cnt != CMAX) lo_off_cnt <= lo_off_cnt + 1'b1;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/hbr_gate_seq.sv
module hbr_gate_seq
    import hbr_pkg::*;
#(
    parameter int DEAD = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bridge_en,
    input  logic       idle,
    input  logic       fault,
    input  logic       phase,
    input  logic       drive_on,
    input  logic       decay_fast,
    input  logic [1:0] rect_policy,
    input  logic       zero_cur,
    input  logic       rev_limit,
    output logic       src_a,
    output logic       snk_a,
    output logic       src_b,
    output logic       snk_b
);
    rect_pol_e       pol;
    logic            active;
    logic            killed;
    logic [LEGS-1:0] want_hi, want_lo;
    logic [LEGS-1:0] leg_hi, leg_lo;

    assign pol = rect_pol_e'(rect_policy);

    hbr_rect_guard guard_i (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .drive_on  (drive_on),
        .pol       (pol),
        .zero_cur  (zero_cur),
        .rev_limit (rev_limit),
        .killed    (killed)
    );

    hbr_pattern pattern_i (
        .bridge_en  (bridge_en),
        .idle       (idle),
        .fault      (fault),
        .phase      (phase),
        .drive_on   (drive_on),
        .decay_fast (decay_fast),
        .pol        (pol),
        .killed     (killed),
        .active     (active),
        .want_hi    (want_hi),
        .want_lo    (want_lo)
    );

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        hbr_leg #(.DEAD(DEAD)) leg_i (
            .clk     (clk),
            .rst     (rst),
            .want_hi (want_hi[i]),
            .want_lo (want_lo[i]),
            .hi      (leg_hi[i]),
            .lo      (leg_lo[i])
        );
    end

    assign src_a = leg_hi[0];
    assign snk_a = leg_lo[0];
    assign src_b = leg_hi[1];
    assign snk_b = leg_lo[1];

endmodule

// File: rtl/hbr_gate_seq_chk.sv
module hbr_gate_seq_chk #(
    parameter int DEAD = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       bridge_en,
    input logic       idle,
    input logic       fault,
    input logic       drive_on,
    input logic [1:0] rect_policy,
    input logic       zero_cur,
    input logic       src_a,
    input logic       snk_a,
    input logic       src_b,
    input logic       snk_b
);
    localparam int CW = $clog2(DEAD + 1);

    logic [3:0]    sw;
    logic [CW-1:0] low_run [4];

    assign sw = {snk_b, src_b, snk_a, src_a};

    // Clocks each switch's leg partner has spent off
    for (genvar k = 0; k < 4; k++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst)                              low_run[k] <= CW'(DEAD);
            else if (sw[k ^ 1])                   low_run[k] <= '0;
            else if (low_run[k] != CW'(DEAD))     low_run[k] <= low_run[k] + 1'b1;
        end
    end

    // R10
    leg_a_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(src_a && snk_a));
    // R10
    leg_b_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(src_b && snk_b));
    // R3
    forced_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!bridge_en || idle || fault) |=> (sw == 4'b0000));
    // R6
    no_rect_decay_chk: assert property (@(posedge clk) disable iff (rst)
        (!drive_on && rect_policy == 2'b01) |=> (sw == 4'b0000));
    // R7
    zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!drive_on && rect_policy == 2'b00 && zero_cur) |=> (sw == 4'b0000));
    // R9
    lowside_no_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!drive_on && rect_policy == 2'b11) |=> (!src_a && !src_b));
    // R11
    src_a_dead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(src_a) |-> (low_run[0] >= CW'(DEAD)));
    // R11
    snk_a_dead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(snk_a) |-> (low_run[1] >= CW'(DEAD)));
    // R11
    src_b_dead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(src_b) |-> (low_run[2] >= CW'(DEAD)));
    // R11
    snk_b_dead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(snk_b) |-> (low_run[3] >= CW'(DEAD)));

endmodule

bind hbr_gate_seq hbr_gate_seq_chk #(.DEAD(DEAD)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bridge_en   (bridge_en),
    .idle        (idle),
    .fault       (fault),
    .drive_on    (drive_on),
    .rect_policy (rect_policy),
    .zero_cur    (zero_cur),
    .src_a       (src_a),
    .snk_a       (snk_a),
    .src_b       (src_b),
    .snk_b       (snk_b)
);

// File: tb/hbr_gate_seq_tb_top.sv
module hbr_gate_seq_tb_top;

    localparam int DEAD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bridge_en = 1'b0, idle = 1'b0, fault = 1'b0;
    logic       phase = 1'b0, drive_on = 1'b0, decay_fast = 1'b0;
    logic [1:0] rect_policy = 2'b00;
    logic       zero_cur = 1'b0, rev_limit = 1'b0;
    logic       src_a, snk_a, src_b, snk_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state, index 0 src_a, 1 snk_a, 2 src_b, 3 snk_b
    bit [3:0] m_out;
    int       last_on [4];
    bit       m_kill;
    int       cyc;
    string    m_tag;

    always #2 clk = ~clk;

    hbr_gate_seq #(.DEAD(DEAD)) dut_i (
        .clk(clk), .rst(rst), .bridge_en(bridge_en), .idle(idle), .fault(fault),
        .phase(phase), .drive_on(drive_on), .decay_fast(decay_fast),
        .rect_policy(rect_policy), .zero_cur(zero_cur), .rev_limit(rev_limit),
        .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b)
    );

    function automatic bit [3:0] expect_pattern(bit act, bit drv, bit ph, bit fst,
                                                bit [1:0] pol, bit kl);
        if (!act) return 4'b0000;
        if (drv) return ph ? 4'b1001 : 4'b0110;              // R2
        if (pol == 2'b01) return 4'b0000;                      // R6
        if (pol == 2'b11) return fst ? (ph ? 4'b0010 : 4'b1000) : 4'b1010; // R9
        if (kl) return 4'b0000;                                // R7 / R8
        if (fst) return ph ? 4'b0110 : 4'b1001;                // R4
        return 4'b1010;                                        // R5
    endfunction

    task automatic model_reset();
        m_out = '0;
        m_kill = 0;
        cyc = 0;
        for (int i = 0; i < 4; i++) last_on[i] = -1000;
    endtask

    task automatic model_edge();
        bit       act, hit;
        bit [3:0] tgt, nxt;
        act = bridge_en && !idle && !fault;
        hit = (rect_policy == 2'b00 && zero_cur) || (rect_policy == 2'b10 && rev_limit);
        tgt = expect_pattern(act, drive_on, phase, decay_fast, rect_policy, m_kill || hit);
        for (int i = 0; i < 4; i++)
            nxt[i] = tgt[i] && (m_out[i] || (!m_out[i ^ 1] && (cyc - last_on[i ^ 1] >= DEAD)));
        for (int i = 0; i < 4; i++)
            if (m_out[i]) last_on[i] = cyc;
        m_kill = (act && !drive_on) ? (m_kill || hit) : 1'b0;
        if (!act)                  m_tag = "R3";
        else if (nxt != tgt)       m_tag = "R11";
        else if (drive_on)         m_tag = "R2";
        else if (rect_policy == 2'b01) m_tag = "R6";
        else if (rect_policy == 2'b11) m_tag = "R9";
        else if (tgt == 4'b0000)   m_tag = (rect_policy == 2'b00) ? "R7" : "R8";
        else                       m_tag = decay_fast ? "R4" : "R5";
        m_out = nxt;
        cyc++;
    endtask

    task automatic check_bits(string tag, bit [3:0] act_v, bit [3:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got %b expected %b (snk_b,src_b,snk_a,src_a) at cycle %0d",
                     tag, act_v, exp_v, cyc);
        end
    endtask

    task automatic step();
        bit [3:0] o;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        o = {snk_b, src_b, snk_a, src_a};
        check_bits(m_tag, o, m_out);
        // R10 leg exclusivity seen at the ports
        checks++;
        if ((src_a && snk_a) || (src_b && snk_b)) begin
            errors++;
            $display("FAIL R10: overlap %b expected no leg with both on", o);
        end
    endtask

    task automatic set_in(bit en, bit idl, bit flt, bit ph, bit drv, bit fst,
                          bit [1:0] pol, bit zc, bit rl);
        bridge_en = en; idle = idl; fault = flt; phase = ph; drive_on = drv;
        decay_fast = fst; rect_policy = pol; zero_cur = zc; rev_limit = rl;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bits("R1", {snk_b, src_b, snk_a, src_a}, 4'b0000);
        rst = 1'b0;
        check_bits("R1", {snk_b, src_b, snk_a, src_a}, 4'b0000);

        // directed: drive phase 1, then reverse, gap of DEAD clocks (R2, R11)
        set_in(1, 0, 0, 1, 1, 0, 2'b00, 0, 0);
        step();
        check_bits("R2", {snk_b, src_b, snk_a, src_a}, 4'b1001);
        repeat (3) step();
        set_in(1, 0, 0, 0, 1, 0, 2'b00, 0, 0);
        step();
        check_bits("R11", {snk_b, src_b, snk_a, src_a}, 4'b0000);
        step();
        step();
        check_bits("R11", {snk_b, src_b, snk_a, src_a}, 4'b0000);
        step();
        check_bits("R2", {snk_b, src_b, snk_a, src_a}, 4'b0110);

        // directed: active policy slow decay, zero current latch (R5, R7)
        set_in(1, 0, 0, 0, 0, 0, 2'b00, 0, 1);
        repeat (4) step();
        check_bits("R5", {snk_b, src_b, snk_a, src_a}, 4'b1010);
        zero_cur = 1'b1;
        step();
        check_bits("R7", {snk_b, src_b, snk_a, src_a}, 4'b0000);
        zero_cur = 1'b0;
        repeat (3) step();
        check_bits("R7", {snk_b, src_b, snk_a, src_a}, 4'b0000);

        // directed: low-side-only fast decay, detects ignored (R9)
        set_in(1, 0, 0, 1, 0, 1, 2'b11, 1, 1);
        repeat (5) step();
        check_bits("R9", {snk_b, src_b, snk_a, src_a}, 4'b0010);

        // random segments
        for (int seg = 0; seg < 3000; seg++) begin
            int len;
            bit en, idl, flt;
            en  = ($urandom_range(0, 15) != 0);
            idl = ($urandom_range(0, 31) == 0);
            flt = ($urandom_range(0, 31) == 0);
            set_in(en, idl, flt, 1'($urandom), 1'($urandom_range(0, 2) == 0),
                   1'($urandom), 2'($urandom), 0, 0);
            len = $urandom_range(1, 8);
            for (int c = 0; c < len; c++) begin
                zero_cur  = ($urandom_range(0, 3) == 0);
                rev_limit = ($urandom_range(0, 3) == 0);
                step();
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule